// File: doc/BRIEF.md
# Tower-Field GF(2^8) Multiplicative Inverter

This block returns the multiplicative inverse of one byte viewed as an element of GF(2^8), where bit i of the byte is the coefficient of x^i. The reducing polynomial is x^8+x^7+x^6+x^5+x^4+x^3+1. It is meant to sit inside a wider inverter that splits a 16-bit element into two bytes and needs a compact byte-level inverse.

Inside, the byte is carried by a linear 8x8 change of basis into a two-level field. In that field a value is a pair (hi, lo) of 4-bit coefficients standing for hi·z + lo. The 4-bit arithmetic reduces modulo the all-ones quartic x^4+x^3+x^2+x+1, and z satisfies z^2 = z + 2, where 2 is the 4-bit element x. The inverse needs three quantities:
- the norm N = 2·hi^2 + hi·lo + lo^2;
- a 4-bit inverse of N;
- two products with that inverse: hi·N^-1 and (hi+lo)·N^-1.

The pair of products is then carried back by the inverse 8x8 matrix. Both matrices and the 4-bit inverse table are worked out during elaboration from the two polynomials. None of them is typed in by hand. The result is held in one output register.

Top module: `tower_inv8`

## Requirements
- R1: For every input byte v other than zero, the output one clock edge after v is sampled is the byte w with v·w = 1 in GF(2^8). Multiplication is taken modulo x^8+x^7+x^6+x^5+x^4+x^3+1 (0x1F9), with bit i of a byte as the coefficient of x^i.
- R2: An input of 0x00 yields 0x00 one edge later.
- R3: An input of 0x01 yields 0x01 one edge later.
- R4: While the synchronous active-high reset is high at a clock edge, the output is cleared to 0x00 at that edge.
- R5: Feeding the output back as the next input returns the original byte one edge later, for any byte.
- R6: A new input may be applied on every clock edge. Each output depends only on the input sampled at the edge before it, with no influence from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset clearing the output |
| elem_i | input | 8 | Field element to invert |
| inv_o | output | 8 | Registered inverse of the element sampled at the previous edge |

## Verification
The bench first walks every byte upward. It then walks every byte downward, so each output follows a very different neighbour. Together these show that every one of the 256 mappings is exact and that no earlier input leaks into later results. A pseudo-random stream changing every cycle checks back-to-back independence. A feedback pass drives each result straight back in and expects the original byte, which separates a true inverse from a table that is only consistent in one direction. Zero, one and a reset pulse applied over a nonzero input cover the edge values, and a wrong zero or reset path shows up there.

// File: rtl/tower_gf_pkg.sv
package tower_gf_pkg;

    localparam int NIB_W  = 4;
    localparam int ELEM_W = 2 * NIB_W;
    localparam int NIB_N  = 1 << NIB_W;
    localparam int ELEM_N = 1 << ELEM_W;

    // all-ones quartic for the 4-bit subfield
    localparam logic [NIB_W:0]  NIB_POLY  = 5'h1F;
    // byte-field modulus x^8+x^7+x^6+x^5+x^4+x^3+1
    localparam logic [ELEM_W:0] BYTE_POLY = 9'h1F9;
    // constant term of z^2 + z + 2
    localparam logic [NIB_W-1:0] QUAD_CONST = 4'h2;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [ELEM_W-1:0] byte_t;

    typedef struct packed {
        nib_t hi;
        nib_t lo;
    } tower_t;

    // one column per input bit
    typedef logic [ELEM_W-1:0][ELEM_W-1:0] lin_map_t;
    typedef logic [NIB_N-1:0][NIB_W-1:0]   nib_lut_t;

    function automatic nib_t nib_mul(nib_t x, nib_t y);
        logic [2*NIB_W-2:0] p;
        p = '0;
        for (int i = 0; i < NIB_W; i++) begin
            if (y[i]) p ^= ({{(NIB_W-1){1'b0}}, x} << i);
        end
        for (int k = 2*NIB_W-2; k >= NIB_W; k--) begin
            if (p[k]) p ^= ({{(NIB_W-2){1'b0}}, NIB_POLY} << (k - NIB_W));
        end
        return p[NIB_W-1:0];
    endfunction

    function automatic tower_t tower_mul(tower_t u, tower_t v);
        tower_t r;
        nib_t   hh;
        hh   = nib_mul(u.hi, v.hi);
        r.hi = hh ^ nib_mul(u.hi, v.lo) ^ nib_mul(u.lo, v.hi);
        r.lo = nib_mul(hh, QUAD_CONST) ^ nib_mul(u.lo, v.lo);
        return r;
    endfunction

    function automatic byte_t apply_map(lin_map_t m, byte_t v);
        byte_t r;
        r = '0;
        for (int i = 0; i < ELEM_W; i++) begin
            if (v[i]) r ^= m[i];
        end
        return r;
    endfunction

    // smallest tower element that is a root of the byte-field modulus
    function automatic tower_t find_root();
        tower_t beta;
        tower_t acc;
        for (int c = 2; c < ELEM_N; c++) begin
            beta = tower_t'(byte_t'(c));
            acc  = '0;
            for (int k = ELEM_W; k >= 0; k--) begin
                acc = tower_mul(acc, beta);
                if (BYTE_POLY[k]) acc ^= tower_t'(byte_t'(1));
            end
            if (acc == '0) return beta;
        end
        return '0;
    endfunction

    function automatic lin_map_t build_fwd();
        lin_map_t m;
        tower_t   beta;
        tower_t   pw;
        beta = find_root();
        pw   = tower_t'(byte_t'(1));
        for (int i = 0; i < ELEM_W; i++) begin
            m[i] = byte_t'(pw);
            pw   = tower_mul(pw, beta);
        end
        return m;
    endfunction

    function automatic lin_map_t build_bwd(lin_map_t fwd);
        lin_map_t m;
        byte_t    img;
        m = '0;
        for (int w = 1; w < ELEM_N; w++) begin
            img = apply_map(fwd, byte_t'(w));
            for (int j = 0; j < ELEM_W; j++) begin
                if (img == (byte_t'(1) << j)) m[j] = byte_t'(w);
            end
        end
        return m;
    endfunction

    function automatic nib_lut_t build_nib_inv();
        nib_lut_t t;
        t = '0;
        for (int v = 1; v < NIB_N; v++) begin
            for (int w = 1; w < NIB_N; w++) begin
                if (nib_mul(nib_t'(v), nib_t'(w)) == nib_t'(1)) t[v] = nib_t'(w);
            end
        end
        return t;
    endfunction

    localparam lin_map_t TO_TOWER    = build_fwd();
    localparam lin_map_t TO_BYTE     = build_bwd(TO_TOWER);
    localparam nib_lut_t NIB_INV_LUT = build_nib_inv();

endpackage

// File: rtl/gf16_mul.sv
module gf16_mul
    import tower_gf_pkg::*;
(
    input  nib_t a_i,
    input  nib_t b_i,
    output nib_t p_o
);

    // AND plane: row i is b shifted by i, gated by a[i]
    logic [NIB_W-1:0][2*NIB_W-2:0] rows;
    logic [2*NIB_W-2:0]            raw;

    for (genvar i = 0; i < NIB_W; i++) begin : g_row
        assign rows[i] = {{(NIB_W-1){1'b0}}, (b_i & {NIB_W{a_i[i]}})} << i;
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < NIB_W; i++) raw ^= rows[i];
    end

    // x^4 = x^3+x^2+x+1, so each high bit folds onto every lower position
    always_comb begin
        logic [2*NIB_W-2:0] acc;
        acc = raw;
        for (int k = 2*NIB_W-2; k >= NIB_W; k--) begin
            if (acc[k]) acc ^= ({{(NIB_W-2){1'b0}}, NIB_POLY} << (k - NIB_W));
        end
        p_o = acc[NIB_W-1:0];
    end

endmodule

// File: rtl/gf16_sqsc.sv
module gf16_sqsc
    import tower_gf_pkg::*;
#(
    parameter nib_t SCALE = 4'h2
) (
    input  nib_t a_i,
    output nib_t q_o
);

    // squaring is linear: spread bits to even positions, then reduce
    logic [2*NIB_W-2:0] spread;
    nib_t               sq;

    always_comb begin
        spread = '0;
        for (int i = 0; i < NIB_W; i++) spread[2*i] = a_i[i];
        for (int k = 2*NIB_W-2; k >= NIB_W; k--) begin
            if (spread[k]) spread ^= ({{(NIB_W-2){1'b0}}, NIB_POLY} << (k - NIB_W));
        end
        sq = spread[NIB_W-1:0];
    end

    if (SCALE == nib_t'(1)) begin : g_plain
        assign q_o = sq;
    end else begin : g_scaled
        gf16_mul u_scale (
            .a_i (sq),
            .b_i (SCALE),
            .p_o (q_o)
        );
    end

endmodule

// File: rtl/gf16_inv.sv
module gf16_inv
    import tower_gf_pkg::*;
(
    input  nib_t a_i,
    output nib_t q_o
);

    // sixteen-entry table derived at elaboration; entry zero stays zero
    assign q_o = NIB_INV_LUT[a_i];

endmodule

// File: rtl/tower_inv8.sv
module tower_inv8
    import tower_gf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] elem_i,
    output logic [7:0] inv_o
);

    tower_t t_in;
    tower_t t_out;
    nib_t   hi_sq2;
    nib_t   lo_sq;
    nib_t   hl_prod;
    nib_t   norm;
    nib_t   norm_inv;
    nib_t   hl_sum;
    byte_t  inv_q;

    assign t_in = tower_t'(apply_map(TO_TOWER, elem_i));

    gf16_sqsc #(.SCALE(QUAD_CONST)) u_hi_sq (
        .a_i (t_in.hi),
        .q_o (hi_sq2)
    );

    gf16_sqsc #(.SCALE(4'h1)) u_lo_sq (
        .a_i (t_in.lo),
        .q_o (lo_sq)
    );

    gf16_mul u_hl_mul (
        .a_i (t_in.hi),
        .b_i (t_in.lo),
        .p_o (hl_prod)
    );

    assign norm   = hi_sq2 ^ hl_prod ^ lo_sq;
    assign hl_sum = t_in.hi ^ t_in.lo;

    gf16_inv u_norm_inv (
        .a_i (norm),
        .q_o (norm_inv)
    );

    gf16_mul u_hi_out (
        .a_i (t_in.hi),
        .b_i (norm_inv),
        .p_o (t_out.hi)
    );

    gf16_mul u_lo_out (
        .a_i (hl_sum),
        .b_i (norm_inv),
        .p_o (t_out.lo)
    );

    always_ff @(posedge clk) begin
        if (rst) inv_q <= '0;
        else     inv_q <= apply_map(TO_BYTE, byte_t'(t_out));
    end

    assign inv_o = inv_q;

    // R1
    map_roundtrip_chk: assert property (@(posedge clk) disable iff (rst)
        apply_map(TO_BYTE, byte_t'(t_in)) == elem_i);

    // R1
    norm_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (elem_i != 8'h00) |-> (norm != 4'h0));

    // R1
    nib_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        (norm != 4'h0) |-> (nib_mul(norm, norm_inv) == 4'h1));

    // R1
    tower_product_chk: assert property (@(posedge clk) disable iff (rst)
        (elem_i != 8'h00) |-> (tower_mul(t_in, t_out) == tower_t'(8'h01)));

    // R2
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        (elem_i == 8'h00) |=> (inv_o == 8'h00));

    // R3
    unit_in_chk: assert property (@(posedge clk) disable iff (rst)
        (elem_i == 8'h01) |=> (inv_o == 8'h01));

    // R4
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (inv_o == 8'h00));

endmodule

// File: tb/tb_tower_inv8.sv
module tb_tower_inv8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] elem_i = 8'h00;
    logic [7:0] inv_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] pend_exp = 8'h00;
    string      pend_tag = "R4";
    bit         done     = 1'b0;

    tower_inv8 dut (
        .clk    (clk),
        .rst    (rst),
        .elem_i (elem_i),
        .inv_o  (inv_o)
    );

    always #4 clk = ~clk;

    function automatic int ref_mul(int a, int b);
        int r = 0;
        int x = a;
        for (int i = 0; i < 8; i++) begin
            if ((b >> i) & 1) r ^= x;
            x = x << 1;
            if (x & 256) x ^= 'h1F9;
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_inv(int a);
        if (a == 0) return 8'h00;
        for (int b = 1; b < 256; b++) begin
            if (ref_mul(a, b) == 1) return 8'(b);
        end
        return 8'h00;
    endfunction

    // check the pending result, then drive the next stimulus;
    // fb selects the value just observed on inv_o as the next input
    task automatic step(input logic r, input logic [7:0] v, input logic [7:0] exp_v,
                        input string tag, input bit fb);
        logic [7:0] seen;
        @(negedge clk);
        seen  = inv_o;
        n_cmp++;
        if (seen !== pend_exp) begin
            n_bad++;
            $display("FAIL %s: inv_o=%02h expected=%02h", pend_tag, seen, pend_exp);
        end
        rst      = r;
        elem_i   = fb ? seen : v;
        pend_exp = r ? 8'h00 : exp_v;
        pend_tag = r ? "R4" : tag;
    endtask

    initial begin
        logic [7:0] lf;
        // reset state, R4
        step(1'b1, 8'h37, 8'h00, "R4", 1'b0);
        step(1'b1, 8'h00, 8'h00, "R4", 1'b0);
        // boundaries, R2 and R3
        step(1'b0, 8'h00, 8'h00, "R2", 1'b0);
        step(1'b0, 8'h01, 8'h01, "R3", 1'b0);
        step(1'b0, 8'h00, 8'h00, "R2", 1'b0);
        // full ascending sweep, R1
        for (int v = 0; v < 256; v++) step(1'b0, 8'(v), ref_inv(v), "R1", 1'b0);
        // descending sweep, R1
        for (int v = 255; v >= 0; v--) step(1'b0, 8'(v), ref_inv(v), "R1", 1'b0);
        // back-to-back pseudo-random stream, R6
        lf = 8'hA5;
        for (int n = 0; n < 200; n++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(1'b0, lf, ref_inv(lf), "R6", 1'b0);
        end
        // feedback of the result returns the original, R5
        for (int v = 0; v < 256; v += 3) begin
            step(1'b0, 8'(v), ref_inv(v), "R1", 1'b0);
            step(1'b0, 8'h00, 8'(v), "R5", 1'b1);
        end
        // reset applied over a nonzero input, R4
        step(1'b0, 8'h53, ref_inv('h53), "R1", 1'b0);
        step(1'b1, 8'hC2, 8'h00, "R4", 1'b0);
        step(1'b0, 8'hC2, ref_inv('hC2), "R1", 1'b0);
        step(1'b0, 8'h01, 8'h01, "R3", 1'b0);
        step(1'b0, 8'h00, 8'h00, "R2", 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule